// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block turns a vector of already-synchronized GPIO inputs into a single interrupt request for a parent interrupt controller. Each pin has its own settings. It can sense a level or an edge. In edge mode it can watch one edge or both edges. A polarity bit selects which level or which edge counts. An enable bit masks the pin. A clear bit acknowledges a pending edge. Pins are grouped 32 to a register word.

Software uses a plain word-addressed read/write port. It writes the configuration words and reads back two status views: raw pending, and pending qualified by enable. An edge event is held until software acknowledges it. To acknowledge, software writes the pin's clear bit to 0 and then to 1. A level event simply tracks the input.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The port address is `{kind[2:0], bank}`, with a 1-bit bank for 64 pins. Pin p lives in bank p/32 at bit p%32. The kinds are 0 sense (1 = edge, 0 = level), 1 both-edges, 2 polarity, 3 enable, 4 clear, 5 raw pending (read-only), 6 masked status (read-only), 7 reserved (reads 0). Kinds 0 to 4 read back the last value written to them.
- R2: While reset is asserted and after it, every configuration word, the clear word and all pending bits are 0 (level mode, active-high), and irq_o is 0.
- R3: In level mode, the pending bit one clock later equals the input XOR polarity. Polarity 0 means active-high and polarity 1 means active-low.
- R4: In single-edge mode, polarity 1 selects the rising edge and polarity 0 selects the falling edge. An edge is found by comparing the input with its value on the previous clock. A detected edge sets the pending bit on the next clock, and the bit stays set until it is cleared.
- R5: With both-edges set in edge mode, either edge sets pending and the polarity bit has no effect.
- R6: A write to the clear word acts only on bits whose stored value goes from 0 to 1. Those bits drop their edge-mode pending bit on the next clock. Writing 1 over a stored 1, or writing 0, leaves pending unchanged.
- R7: In level mode a clear has no lasting effect. Pending stays 1 while the qualified level is still active.
- R8: When an edge is detected on the same clock as a clear rise for that pin, the pin's pending bit stays set.
- R9: Masked status equals raw pending AND enable, and irq_o is the OR of all masked status bits. With every enable at 0, irq_o stays 0.
- R10: Writes to kinds 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Synchronized GPIO input levels |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | ADDR_W | Word address `{kind, bank}` |
| reg_wdata_i | input | WORD_W | Write data |
| reg_rdata_o | output | WORD_W | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The pins are first driven with static level patterns under both polarities, which shows whether active-high and active-low are both respected. Next come isolated rising and falling steps in single-edge mode, one bank set to each polarity, which separates rising from falling selection and shows whether pending is sticky. Toggles with both-edges set show that polarity is really ignored. Clear sequences follow: 1-over-1, write 0, a genuine rise, a rise against an active level, and a rise in the same cycle as an edge. These tell transition-triggered clearing apart from write-one clearing and show which side wins a collision. A final pseudo-random phase mixes writes and pin changes, and the result is compared every clock against a behavioural model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_SENSE  = 3'd0,
    K_BOTH   = 3'd1,
    K_POL    = 3'd2,
    K_EN     = 3'd3,
    K_CLR    = 3'd4,
    K_RAW    = 3'd5,
    K_MASKED = 3'd6,
    K_NONE   = 3'd7
  } reg_kind_e;

  function automatic int unsigned bank_w(input int unsigned nb);
    return (nb > 1) ? $clog2(nb) : 1;
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned BANK_W   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  reg_kind_e           kind_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [NUM_PINS-1:0] sense_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [NUM_PINS-1:0] clr_rise_o
);
  localparam int unsigned NUM_BANKS = NUM_PINS / WORD_W;

  logic [NUM_PINS-1:0] sense_q, both_q, pol_q, en_q, clr_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = we_i && (bank_i == BANK_W'(b));

    // clear acts on stored 0 -> 1 only
    assign clr_rise_o[b*WORD_W +: WORD_W] =
      (sel && kind_i == K_CLR) ? (wdata_i & ~clr_q[b*WORD_W +: WORD_W]) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sense_q[b*WORD_W +: WORD_W] <= '0;
        both_q [b*WORD_W +: WORD_W] <= '0;
        pol_q  [b*WORD_W +: WORD_W] <= '0;
        en_q   [b*WORD_W +: WORD_W] <= '0;
        clr_q  [b*WORD_W +: WORD_W] <= '0;
      end else if (sel) begin
        unique case (kind_i)
          K_SENSE: sense_q[b*WORD_W +: WORD_W] <= wdata_i;
          K_BOTH:  both_q [b*WORD_W +: WORD_W] <= wdata_i;
          K_POL:   pol_q  [b*WORD_W +: WORD_W] <= wdata_i;
          K_EN:    en_q   [b*WORD_W +: WORD_W] <= wdata_i;
          K_CLR:   clr_q  [b*WORD_W +: WORD_W] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign sense_o = sense_q;
  assign both_o  = both_q;
  assign pol_o   = pol_q;
  assign en_o    = en_q;
  assign clr_o   = clr_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NUM_PINS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] clr_rise_i,
  output logic [NUM_PINS-1:0] edge_hit_o,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] pin_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= pin_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, lvl, nxt;
    assign rise = pin_i[i] & ~pin_q[i];
    assign fall = ~pin_i[i] & pin_q[i];
    assign edge_hit_o[i] = both_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign lvl  = pin_i[i] ^ pol_i[i];
    // edge wins over a simultaneous clear
    assign nxt  = sense_i[i] ? (edge_hit_o[i] | (pend_q[i] & ~clr_rise_i[i])) : lvl;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= nxt;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_irq_readout.sv
module gpio_irq_readout
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 64,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned BANK_W   = 1
) (
  input  reg_kind_e           kind_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned NUM_BANKS = NUM_PINS / WORD_W;

  logic [NUM_PINS-1:0] masked;
  assign masked = pend_i & en_i;
  assign irq_o  = |masked;

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_i == BANK_W'(b)) begin
        unique case (kind_i)
          K_SENSE:  rdata_o = sense_i[b*WORD_W +: WORD_W];
          K_BOTH:   rdata_o = both_i [b*WORD_W +: WORD_W];
          K_POL:    rdata_o = pol_i  [b*WORD_W +: WORD_W];
          K_EN:     rdata_o = en_i   [b*WORD_W +: WORD_W];
          K_CLR:    rdata_o = clr_i  [b*WORD_W +: WORD_W];
          K_RAW:    rdata_o = pend_i [b*WORD_W +: WORD_W];
          K_MASKED: rdata_o = masked [b*WORD_W +: WORD_W];
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 64,
  parameter int unsigned WORD_W    = 32,
  localparam int unsigned NUM_BANKS = NUM_PINS / WORD_W,
  localparam int unsigned BANK_W    = bank_w(NUM_BANKS),
  localparam int unsigned ADDR_W    = KIND_W + BANK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  output logic                irq_o
);
  reg_kind_e           kind;
  logic [BANK_W-1:0]   bank;
  logic [NUM_PINS-1:0] sense_w, both_w, pol_w, en_w, clr_w, clr_rise_w;
  logic [NUM_PINS-1:0] pend_w, edge_hit_w;

  assign kind = reg_kind_e'(reg_addr_i[ADDR_W-1 -: KIND_W]);
  assign bank = reg_addr_i[BANK_W-1:0];

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .BANK_W(BANK_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .kind_i     (kind),
    .bank_i     (bank),
    .wdata_i    (reg_wdata_i),
    .sense_o    (sense_w),
    .both_o     (both_w),
    .pol_o      (pol_w),
    .en_o       (en_w),
    .clr_o      (clr_w),
    .clr_rise_o (clr_rise_w)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .sense_i    (sense_w),
    .both_i     (both_w),
    .pol_i      (pol_w),
    .clr_rise_i (clr_rise_w),
    .edge_hit_o (edge_hit_w),
    .pend_o     (pend_w)
  );

  gpio_irq_readout #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .BANK_W(BANK_W)) u_readout (
    .kind_i  (kind),
    .bank_i  (bank),
    .sense_i (sense_w),
    .both_i  (both_w),
    .pol_i   (pol_w),
    .en_i    (en_w),
    .clr_i   (clr_w),
    .pend_i  (pend_w),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned NUM_PINS = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [NUM_PINS-1:0] sense_q,
  input logic [NUM_PINS-1:0] pol_q,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] pend_q,
  input logic [NUM_PINS-1:0] clr_rise,
  input logic [NUM_PINS-1:0] edge_hit
);
  p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  p_level_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (((pend_q ^ $past(pin_i ^ pol_q)) & ~$past(sense_q)) == '0));

  p_edge_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(pend_q & sense_q & ~clr_rise) & ~pend_q) == '0));

  p_clear_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(clr_rise & sense_q & ~edge_hit) & pend_q) == '0));

  p_edge_beats_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (($past(clr_rise & sense_q & edge_hit) & ~pend_q) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .pin_i    (pin_i),
  .sense_q  (sense_w),
  .pol_q    (pol_w),
  .en_q     (en_w),
  .pend_q   (pend_w),
  .clr_rise (clr_rise_w),
  .edge_hit (edge_hit_w)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int NP = 64;
  localparam int WW = 32;
  localparam int NB = 2;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          irq;

  int    nvec = 0;
  int    nfail = 0;
  bit    done = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit m_sense[NP], m_both[NP], m_pol[NP], m_en[NP], m_clr[NP], m_pend[NP], m_prev[NP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_sense[i] = 0; m_both[i] = 0; m_pol[i] = 0; m_en[i] = 0;
        m_clr[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
      end
    end else begin
      bit nxt[NP];
      int kind, bk;
      kind = int'(addr) / NB;
      bk   = int'(addr) % NB;
      for (int i = 0; i < NP; i++) begin
        bit crise, r, f, eh;
        crise = we && kind == 4 && bk == i / WW && wdata[i % WW] && !m_clr[i];
        r  = pins[i] && !m_prev[i];
        f  = !pins[i] && m_prev[i];
        eh = m_both[i] ? (r || f) : (m_pol[i] ? r : f);
        if (m_sense[i]) nxt[i] = eh || (m_pend[i] && !crise);
        else            nxt[i] = pins[i] != m_pol[i];
      end
      for (int i = 0; i < NP; i++) begin
        m_pend[i] = nxt[i];
        m_prev[i] = pins[i];
      end
      if (we) begin
        for (int j = 0; j < WW; j++) begin
          int p;
          p = bk * WW + j;
          case (kind)
            0: m_sense[p] = wdata[j];
            1: m_both[p]  = wdata[j];
            2: m_pol[p]   = wdata[j];
            3: m_en[p]    = wdata[j];
            4: m_clr[p]   = wdata[j];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [WW-1:0] m_read(input int a);
    logic [WW-1:0] v;
    int kind, bk;
    kind = a / NB;
    bk   = a % NB;
    v = '0;
    for (int j = 0; j < WW; j++) begin
      int p;
      p = bk * WW + j;
      case (kind)
        0: v[j] = m_sense[p];
        1: v[j] = m_both[p];
        2: v[j] = m_pol[p];
        3: v[j] = m_en[p];
        4: v[j] = m_clr[p];
        5: v[j] = m_pend[p];
        6: v[j] = m_pend[p] & m_en[p];
        default: v[j] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic check_now();
    logic [WW-1:0] er;
    logic ei;
    er = m_read(int'(addr));
    ei = 1'b0;
    for (int i = 0; i < NP; i++) ei |= m_pend[i] & m_en[i];
    nvec++;
    if (rdata !== er || irq !== ei) begin
      nfail++;
      $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
               cur_req, addr, rdata, irq, er, ei);
    end
  endtask

  task automatic step(input logic w, input int a, input logic [WW-1:0] d);
    we = w; addr = a[AW-1:0]; wdata = d;
    @(negedge clk);
    check_now();
  endtask

  task automatic wr(input int a, input logic [WW-1:0] d); step(1'b1, a, d); endtask
  task automatic rd(input int a); step(1'b0, a, '0); endtask

  function automatic int A(input int kind, input int bank);
    return kind * NB + bank;
  endfunction

  task automatic clear_bank(input int b);
    wr(A(4, b), '0);
    wr(A(4, b), '1);
  endtask

  initial begin
    logic [63:0] lf;
    @(negedge clk);
    // R2: reset state on every address
    cur_req = "R2";
    for (int a = 0; a < 16; a++) rd(a);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) rd(a);

    // R1: readback of configuration kinds
    cur_req = "R1";
    wr(A(1, 0), 32'hA5A5_A5A5); rd(A(1, 0));
    wr(A(2, 1), 32'h1234_5678); rd(A(2, 1));
    wr(A(3, 0), 32'hFFFF_0000); rd(A(3, 0)); rd(A(6, 0));
    wr(A(4, 1), 32'h0000_000F); rd(A(4, 1));
    wr(A(1, 0), '0); wr(A(2, 1), '0); wr(A(4, 1), '0);

    // R3: level mode, both polarities
    cur_req = "R3";
    wr(A(3, 0), '1); wr(A(3, 1), '1);
    pins = 64'h8000_0001_0000_0F0F; rd(A(5, 0)); rd(A(5, 1)); rd(A(6, 0));
    pins = 64'h0000_0000_0000_0000; rd(A(5, 0)); rd(A(5, 1));
    wr(A(2, 0), 32'hFFFF_0000); rd(A(5, 0));
    pins = 64'h0000_0000_00FF_00FF; rd(A(5, 0)); rd(A(6, 0));
    wr(A(2, 0), '0); pins = '0; rd(A(5, 0));

    // R4: single edge, bank0 rising, bank1 falling, sticky
    cur_req = "R4";
    wr(A(2, 0), '1); wr(A(0, 0), '1); wr(A(0, 1), '1);
    clear_bank(0); clear_bank(1); rd(A(5, 0));
    pins = 64'h0000_0001_0000_0003; rd(A(5, 0)); rd(A(5, 1));
    pins = '0; rd(A(5, 1)); rd(A(5, 0)); rd(A(5, 0));

    // R5: both edges ignore polarity
    cur_req = "R5";
    wr(A(4, 0), '0); wr(A(4, 0), '1); rd(A(5, 0));
    wr(A(1, 0), 32'h0000_00F0);
    pins = 64'h0000_0000_0000_0030; rd(A(5, 0));
    wr(A(4, 0), '0); wr(A(4, 0), '1); rd(A(5, 0));
    pins = '0; rd(A(5, 0)); rd(A(5, 0));

    // R6: clear is a 0 -> 1 transition, not write-one
    cur_req = "R6";
    wr(A(4, 0), '1); rd(A(5, 0));
    wr(A(4, 0), 32'hFFFF_FFEF); rd(A(5, 0));
    wr(A(4, 0), 32'hFFFF_FFFF); rd(A(5, 0)); rd(A(4, 0));

    // R7: clear against an active level
    cur_req = "R7";
    wr(A(0, 1), '0); wr(A(2, 1), '0);
    pins = 64'h0000_0008_0000_0000; rd(A(5, 1));
    wr(A(4, 1), '0); wr(A(4, 1), 32'h0000_0008); rd(A(5, 1)); rd(A(5, 1));
    pins = '0; rd(A(5, 1));

    // R8: edge in the same cycle as clear rise
    cur_req = "R8";
    wr(A(1, 0), '0); wr(A(4, 0), '0);
    pins = 64'h0000_0000_0000_0100; wr(A(4, 0), 32'h0000_0100); rd(A(5, 0)); rd(A(5, 0));

    // R9: enable masking and combined output
    cur_req = "R9";
    wr(A(3, 1), '0); wr(A(3, 0), 32'h0000_0100); rd(A(6, 0));
    wr(A(3, 0), 32'h0000_0001); rd(A(6, 0)); rd(A(5, 0));
    wr(A(3, 0), 32'h0000_0100); rd(A(6, 0));
    wr(A(3, 0), '0); rd(A(6, 0)); rd(A(5, 0));

    // R10: read-only kinds ignore writes
    cur_req = "R10";
    wr(A(5, 0), '0); rd(A(5, 0));
    wr(A(6, 1), '1); rd(A(6, 1)); rd(A(5, 1));
    wr(A(7, 0), '1); rd(A(7, 0)); rd(A(5, 0));

    // mixed pseudo-random traffic against the model
    cur_req = "R4";
    lf = 64'hC0FF_EE12_3456_789B;
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      if (lf[7:5] == 3'd0) pins = pins ^ {lf[31:0], lf[63:32]};
      else if (lf[7:5] == 3'd1) pins = pins ^ (64'd1 << lf[13:8]);
      step(lf[17:16] == 2'b00, int'(lf[23:20]), lf[55:24]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog %s: actual hung, expected completion", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule